// File: doc/BRIEF.md
# MMU Fault Status Capture Register

This block holds the fault report of a memory management unit. A translation or bus unit hands it fault events. Each event carries six things: a fault type, an access type, a page-table level, a set of error-class flags, a flag that says the address is valid, and the faulting address. The block packs these fields into one status word. It keeps the faulting address in a companion address register.

Software reads either register through a small read port. A select input picks the register. The read data follows the select in the same cycle. Reading the status register clears it on that clock edge, so a handler sees each report once.

Between reads, the error-class flags of successive events add up by OR. The fault, access and level fields always show the newest event. An overwrite bit records that a fault arrived while an earlier one was still unread.

Top module: `mmu_fault_capture`

## Requirements
- R1: After reset, both the status word and the address register read as zero.
- R2: An event is packed into the status word at fixed positions, and status bits above 14 read as zero.
  - Fault type is at bits 4:2.
  - Access type is at bits 7:5: bit 5 is supervisor, bit 6 is instruction fetch, bit 7 is store.
  - Page-table level is at bits 9:8.
  - `evt_err` maps directly onto bits 14:10: bit 10 is bus error, bit 11 is timeout, bit 12 is uncorrectable, bits 14:13 are the parity code.
- R3: An event with `evt_addr_vld` high loads `evt_addr` into the address register and sets status bit 1.
- R4: An event with `evt_addr_vld` low leaves the address register unchanged and does not set status bit 1.
- R5: Status bits 14:10 accumulate by bitwise OR across events until the status register is read.
- R6: A second event before the status read replaces bits 9:2 with the newest event's values and sets the overwrite bit 0.
- R7: Status read and clear.
  - With `reg_sel`=0, `rd_data` shows the current status in the same cycle.
  - A `reg_rd` pulse with `reg_sel`=0 clears the status word at that clock edge.
  - A read with `reg_sel`=1 returns the address and clears nothing.
- R8: When an event and a status read fall in the same cycle, the read returns the old word. Afterwards the status holds only the new event: no overwrite bit, and errors from that event alone.
- R9: Bits 0 and 1 stay set across later events until the status is read, and the status is unchanged in cycles with no event and no status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_valid | input | 1 | Fault event strobe |
| evt_ftype | input | 3 | Fault type code |
| evt_atype | input | 3 | Access type (supervisor, fetch, store) |
| evt_level | input | 2 | Page-table level of the fault |
| evt_err | input | 5 | Error flags: bus, timeout, uncorrectable, parity code[1:0] |
| evt_addr_vld | input | 1 | The event's address is valid |
| evt_addr | input | AW | Faulting address |
| reg_rd | input | 1 | Read strobe; clears status when reg_sel is 0 |
| reg_sel | input | 1 | 0 selects status, 1 selects address |
| rd_data | output | DW | Selected register value |

## Verification
The hardest case to reach is an event that lands in exactly the clock cycle where software reads the status. The bench drives the event and the read strobe on the same falling edge. It samples `rd_data` before the rising edge and checks that the old word is returned. It then inspects the status without a read strobe, to confirm that the word holds only the new event. The same non-clearing inspection is used to prove two things after multi-event sequences: that the overwrite and valid-address bits are sticky, and that an address read leaves the status intact.

// File: rtl/mfc_pkg.sv
package mfc_pkg;

  localparam int FT_W  = 3;
  localparam int AT_W  = 3;
  localparam int LV_W  = 2;
  localparam int ERR_W = 5;

  // Packed status word, MSB first; bit positions are decoded by software.
  typedef struct packed {
    logic [1:0]      par;   // 14:13 parity code
    logic            unc;   // 12 uncorrectable
    logic            tmo;   // 11 timeout
    logic            bus;   // 10 bus error
    logic [LV_W-1:0] lvl;   // 9:8 table level
    logic [AT_W-1:0] acc;   // 7:5 access type
    logic [FT_W-1:0] ftype; // 4:2 fault type
    logic            fav;   // 1 address valid
    logic            ow;    // 0 overwritten
  } mfc_stat_t;

  localparam int STAT_W  = $bits(mfc_stat_t);
  localparam int ERR_LSB = 10;
  localparam int ERR_MSB = ERR_LSB + ERR_W - 1;
  localparam int FT_LSB  = 2;
  localparam int FT_MSB  = FT_LSB + FT_W - 1;

endpackage

// File: rtl/mfc_rst_sync.sv
module mfc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/mfc_status_next.sv
module mfc_status_next
  import mfc_pkg::*;
(
  input  mfc_stat_t        cur,
  input  logic             pend,
  input  logic             evt_valid,
  input  logic [FT_W-1:0]  evt_ftype,
  input  logic [AT_W-1:0]  evt_atype,
  input  logic [LV_W-1:0]  evt_level,
  input  logic [ERR_W-1:0] evt_err,
  input  logic             evt_addr_vld,
  input  logic             rd_clr,
  output mfc_stat_t        nxt,
  output logic             nxt_pend,
  output logic             upd
);
  mfc_stat_t base;
  logic      base_pend;

  always_comb begin
    // A status read empties the word before a same-cycle event is merged.
    base      = rd_clr ? '0   : cur;
    base_pend = rd_clr ? 1'b0 : pend;
    nxt       = base;
    nxt_pend  = base_pend;
    if (evt_valid) begin
      nxt.ftype = evt_ftype;
      nxt.acc   = evt_atype;
      nxt.lvl   = evt_level;
      {nxt.par, nxt.unc, nxt.tmo, nxt.bus} =
        {base.par, base.unc, base.tmo, base.bus} | evt_err;
      nxt.fav   = base.fav | evt_addr_vld;
      nxt.ow    = base.ow | base_pend;
      nxt_pend  = 1'b1;
    end
    upd = evt_valid | rd_clr;
  end
endmodule

// File: rtl/mfc_addr_reg.sv
module mfc_addr_reg #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_sn,
  input  logic          load,
  input  logic [AW-1:0] d,
  output logic [AW-1:0] q
);
  logic [AW-1:0] q_nxt;

  always_comb q_nxt = load ? d : q;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) q <= '0;
    else         q <= q_nxt;
  end
endmodule

// File: rtl/mmu_fault_capture.sv
module mmu_fault_capture
  import mfc_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_valid,
  input  logic [FT_W-1:0]  evt_ftype,
  input  logic [AT_W-1:0]  evt_atype,
  input  logic [LV_W-1:0]  evt_level,
  input  logic [ERR_W-1:0] evt_err,
  input  logic             evt_addr_vld,
  input  logic [AW-1:0]    evt_addr,
  input  logic             reg_rd,
  input  logic             reg_sel,
  output logic [DW-1:0]    rd_data
);
  localparam int PAD_W = DW - STAT_W;

  logic      rst_sn;
  mfc_stat_t stat_q, stat_nxt;
  logic      pend_q, pend_nxt;
  logic      stat_upd;
  logic      rd_clr;
  logic      addr_load;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] addr_view;

  mfc_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  assign rd_clr    = reg_rd & ~reg_sel;
  assign addr_load = evt_valid & evt_addr_vld;

  mfc_status_next u_next (
    .cur          (stat_q),
    .pend         (pend_q),
    .evt_valid    (evt_valid),
    .evt_ftype    (evt_ftype),
    .evt_atype    (evt_atype),
    .evt_level    (evt_level),
    .evt_err      (evt_err),
    .evt_addr_vld (evt_addr_vld),
    .rd_clr       (rd_clr),
    .nxt          (stat_nxt),
    .nxt_pend     (pend_nxt),
    .upd          (stat_upd)
  );

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      stat_q <= '0;
      pend_q <= 1'b0;
    end else if (stat_upd) begin
      stat_q <= stat_nxt;
      pend_q <= pend_nxt;
    end
  end

  mfc_addr_reg #(.AW(AW)) u_addr (
    .clk    (clk),
    .rst_sn (rst_sn),
    .load   (addr_load),
    .d      (evt_addr),
    .q      (addr_q)
  );

  generate
    if (AW >= DW) begin : g_addr_trunc
      assign addr_view = addr_q[DW-1:0];
    end else begin : g_addr_ext
      assign addr_view = {{(DW-AW){1'b0}}, addr_q};
    end
  endgenerate

  always_comb begin
    if (reg_sel) rd_data = addr_view;
    else         rd_data = {{PAD_W{1'b0}}, stat_q};
  end
endmodule

// File: rtl/mfc_fault_capture_chk.sv
module mfc_fault_capture_chk
  import mfc_pkg::*;
#(
  parameter int AW = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evt_valid,
  input logic [FT_W-1:0]   evt_ftype,
  input logic              evt_addr_vld,
  input logic [AW-1:0]     evt_addr,
  input logic              reg_rd,
  input logic              reg_sel,
  input logic [STAT_W-1:0] stat_q,
  input logic              pend_q,
  input logic [AW-1:0]     addr_q
);
  logic rd_stat;
  assign rd_stat = reg_rd & ~reg_sel;

  p_addr_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_addr_vld) |=> (addr_q == $past(evt_addr) && stat_q[1]));

  p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_valid && evt_addr_vld) |=> $stable(addr_q));

  p_err_accum_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !rd_stat) |=>
      ((stat_q[ERR_MSB:ERR_LSB] & $past(stat_q[ERR_MSB:ERR_LSB]))
        == $past(stat_q[ERR_MSB:ERR_LSB])));

  p_overwrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !rd_stat && pend_q) |=> stat_q[0]);

  p_read_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !evt_valid) |=> (stat_q == '0));

  p_coincide_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && evt_valid) |=>
      (!stat_q[0] && stat_q[FT_MSB:FT_LSB] == $past(evt_ftype)));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_valid && !rd_stat) |=> $stable(stat_q));
endmodule

bind mmu_fault_capture mfc_fault_capture_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sn),
  .evt_valid    (evt_valid),
  .evt_ftype    (evt_ftype),
  .evt_addr_vld (evt_addr_vld),
  .evt_addr     (evt_addr),
  .reg_rd       (reg_rd),
  .reg_sel      (reg_sel),
  .stat_q       (stat_q),
  .pend_q       (pend_q),
  .addr_q       (addr_q)
);

// File: tb/mmu_fault_capture_tb.sv
module mmu_fault_capture_tb;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk;
  logic          rst_n;
  logic          evt_valid;
  logic [2:0]    evt_ftype;
  logic [2:0]    evt_atype;
  logic [1:0]    evt_level;
  logic [4:0]    evt_err;
  logic          evt_addr_vld;
  logic [AW-1:0] evt_addr;
  logic          reg_rd;
  logic          reg_sel;
  logic [DW-1:0] rd_data;

  int checks;
  int fails;
  bit done;

  mmu_fault_capture #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ftype(evt_ftype),
    .evt_atype(evt_atype), .evt_level(evt_level), .evt_err(evt_err),
    .evt_addr_vld(evt_addr_vld), .evt_addr(evt_addr), .reg_rd(reg_rd),
    .reg_sel(reg_sel), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Status word layout from R2: {17'b0, err[4:0], level, access, ftype, fav, ow}
  function automatic logic [DW-1:0] pk(input logic [2:0] ft, input logic [2:0] at,
                                       input logic [1:0] lv, input logic [4:0] er,
                                       input logic fav, input logic ow);
    return {17'b0, er, lv, at, ft, fav, ow};
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock step: drives at the falling edge, samples rd_data before the rising edge.
  task automatic step(input logic ev, input logic [2:0] ft, input logic [2:0] at,
                      input logic [1:0] lv, input logic [4:0] er, input logic av,
                      input logic [AW-1:0] ad, input logic rd, input logic sel,
                      output logic [DW-1:0] d);
    @(negedge clk);
    evt_valid = ev; evt_ftype = ft; evt_atype = at; evt_level = lv;
    evt_err = er; evt_addr_vld = av; evt_addr = ad; reg_rd = rd; reg_sel = sel;
    #1 d = rd_data;
    @(posedge clk);
    #1;
    evt_valid = 1'b0; reg_rd = 1'b0;
  endtask

  task automatic ev(input logic [2:0] ft, input logic [2:0] at, input logic [1:0] lv,
                    input logic [4:0] er, input logic av, input logic [AW-1:0] ad);
    logic [DW-1:0] d;
    step(1'b1, ft, at, lv, er, av, ad, 1'b0, 1'b0, d);
  endtask

  task automatic rd(input logic sel, output logic [DW-1:0] d);
    step(1'b0, 3'd0, 3'd0, 2'd0, 5'd0, 1'b0, '0, 1'b1, sel, d);
  endtask

  // Look at a register without a read strobe (no clear).
  task automatic peek(input logic sel, output logic [DW-1:0] d);
    @(negedge clk);
    reg_rd = 1'b0; reg_sel = sel;
    #1 d = rd_data;
  endtask

  task automatic t_reset;
    logic [DW-1:0] d;
    peek(1'b0, d); chk("R1 status", d, '0);
    peek(1'b1, d); chk("R1 address", d, '0);
  endtask

  task automatic t_single;
    logic [DW-1:0] d;
    ev(3'd5, 3'b101, 2'd2, 5'b00001, 1'b1, 32'hDEAD_BEE0);
    peek(1'b0, d); chk("R2 packing", d, pk(3'd5, 3'b101, 2'd2, 5'b00001, 1'b1, 1'b0));
    peek(1'b1, d); chk("R3 address capture", d, 32'hDEAD_BEE0);
    rd(1'b1, d);   chk("R7 address read", d, 32'hDEAD_BEE0);
    peek(1'b0, d); chk("R7 address read keeps status", d, pk(3'd5, 3'b101, 2'd2, 5'b00001, 1'b1, 1'b0));
    rd(1'b0, d);   chk("R7 status read value", d, pk(3'd5, 3'b101, 2'd2, 5'b00001, 1'b1, 1'b0));
    peek(1'b0, d); chk("R7 cleared after read", d, '0);
    peek(1'b1, d); chk("R7 address kept after status read", d, 32'hDEAD_BEE0);
  endtask

  task automatic t_no_addr;
    logic [DW-1:0] d;
    ev(3'd1, 3'b010, 2'd3, 5'b00000, 1'b0, 32'h0000_1234);
    peek(1'b1, d); chk("R4 address unchanged", d, 32'hDEAD_BEE0);
    peek(1'b0, d); chk("R4 fav clear", d, pk(3'd1, 3'b010, 2'd3, 5'b0, 1'b0, 1'b0));
    rd(1'b0, d);
  endtask

  task automatic t_accum;
    logic [DW-1:0] d;
    ev(3'd2, 3'b000, 2'd1, 5'b00010, 1'b1, 32'hA000_0040);
    ev(3'd6, 3'b110, 2'd0, 5'b01100, 1'b0, 32'hFFFF_FFFF);
    peek(1'b0, d); chk("R5/R6 accumulate and overwrite", d, pk(3'd6, 3'b110, 2'd0, 5'b01110, 1'b1, 1'b1));
    peek(1'b1, d); chk("R4 address from first event", d, 32'hA000_0040);
    repeat (3) @(negedge clk);
    peek(1'b0, d); chk("R9 idle hold", d, pk(3'd6, 3'b110, 2'd0, 5'b01110, 1'b1, 1'b1));
    ev(3'd4, 3'b001, 2'd2, 5'b00000, 1'b0, '0);
    peek(1'b0, d); chk("R9 sticky ow and fav", d, pk(3'd4, 3'b001, 2'd2, 5'b01110, 1'b1, 1'b1));
    rd(1'b0, d);
    peek(1'b0, d); chk("R7 clear after accumulation", d, '0);
  endtask

  task automatic t_coincide;
    logic [DW-1:0] d;
    ev(3'd3, 3'b100, 2'd1, 5'b00101, 1'b0, '0);
    step(1'b1, 3'd4, 3'b011, 2'd3, 5'b10000, 1'b1, 32'h0BAD_F00C, 1'b1, 1'b0, d);
    chk("R8 read returns old word", d, pk(3'd3, 3'b100, 2'd1, 5'b00101, 1'b0, 1'b0));
    peek(1'b0, d); chk("R8 new event kept alone", d, pk(3'd4, 3'b011, 2'd3, 5'b10000, 1'b1, 1'b0));
    peek(1'b1, d); chk("R3 address on coincident event", d, 32'h0BAD_F00C);
    ev(3'd1, 3'b000, 2'd0, 5'b00000, 1'b0, '0);
    peek(1'b0, d); chk("R6 overwrite after coincident", d, pk(3'd1, 3'b000, 2'd0, 5'b10000, 1'b1, 1'b1));
    rd(1'b0, d);
  endtask

  task automatic t_all_ones;
    logic [DW-1:0] d;
    ev(3'd7, 3'b111, 2'd3, 5'b11111, 1'b1, 32'hFFFF_FFFC);
    peek(1'b0, d); chk("R2 full fields, upper bits zero", d, 32'h0000_7FFE);
    rd(1'b0, d);   chk("R7 read full word", d, 32'h0000_7FFE);
    peek(1'b0, d); chk("R7 cleared", d, '0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    rst_n = 1'b0; evt_valid = 1'b0; evt_ftype = '0; evt_atype = '0; evt_level = '0;
    evt_err = '0; evt_addr_vld = 1'b0; evt_addr = '0; reg_rd = 1'b0; reg_sel = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset();
    t_single();
    t_no_addr();
    t_accum();
    t_coincide();
    t_all_ones();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule